// File: doc/BRIEF.md
# Register Stack Push/Pull Sequencer

This block saves a selected set of processor registers to a downward-growing stack in byte-wide memory, or restores such a set from it. A start strobe supplies an 8-bit select mask, the direction, which pointer is active (system S or user U), and a snapshot of every register. The block then makes one byte access per clock until every selected register has been moved. When the sequence ends it presents the final pointer, the registers as they now stand and the number of bus cycles used.

The same engine serves interrupt entry, which saves everything, and explicit save/restore of a register subset. Decoding the opcode that asks for a transfer and choosing between interrupts are the caller's job.

Top module: `stack_seq`

## Requirements
- R1: Mask bits select registers by position: bit 0 condition codes, bit 1 A, bit 2 B, bit 3 direct page, bit 4 X, bit 5 Y, bit 6 the opposite stack pointer, bit 7 PC. Bits 4 to 7 are 16-bit registers and bits 0 to 3 are 8-bit registers.
- R2: A push (`pull`=0) decrements the pointer before each byte write. It stores the registers from bit 7 down to bit 0. A 16-bit register writes its low byte first, so its high byte ends at the lower address.
- R3: A pull (`pull`=1) reads at the pointer and then increments it. It loads the registers from bit 0 up to bit 7, and a 16-bit register takes its high byte from the lower address.
- R4: Bit 6 moves U when the active pointer is S (`use_u`=0), and moves S when the active pointer is U (`use_u`=1).
- R5: Exactly one memory access happens per clock while busy. `cyc_out` at completion equals 2 per selected 16-bit register plus 1 per selected 8-bit register.
- R6: At completion `sp_out` holds the final pointer: the start pointer minus the byte count for a push, plus the byte count for a pull.
- R7: A zero mask makes no memory access. It pulses `done` in the cycle after start, with `sp_out` equal to the start pointer and `cyc_out` zero.
- R8: A start strobe while busy is ignored and does not change the running sequence or its results.
- R9: After reset `busy`, `done`, `mem_wr` and `mem_rd` are low.
- R10: After a pull, each selected register output shows the byte or bytes read from memory. Unselected register outputs keep the value they had at start.
- R11: `mem_wr` and `mem_rd` are never high together, and `done` is a one-cycle pulse one clock after the last access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (accepted when not busy) |
| pull | input | 1 | 1 = pull from stack, 0 = push to stack |
| use_u | input | 1 | 1 = active pointer is U, 0 = active pointer is S |
| mask | input | 8 | Register select mask |
| cc_in | input | 8 | Condition code value |
| a_in | input | 8 | Accumulator A value |
| b_in | input | 8 | Accumulator B value |
| dp_in | input | 8 | Direct page value |
| x_in | input | 16 | Index X value |
| y_in | input | 16 | Index Y value |
| s_in | input | 16 | System stack pointer |
| u_in | input | 16 | User stack pointer |
| pc_in | input | 16 | Program counter |
| mem_addr | output | 16 | Byte address |
| mem_wr | output | 1 | Write strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, same cycle as `mem_rd` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 16 | Final active stack pointer |
| cyc_out | output | 5 | Bus cycles used by the last sequence |
| cc_out | output | 8 | Condition code after sequence |
| a_out | output | 8 | A after sequence |
| b_out | output | 8 | B after sequence |
| dp_out | output | 8 | Direct page after sequence |
| x_out | output | 16 | X after sequence |
| y_out | output | 16 | Y after sequence |
| osp_out | output | 16 | Opposite stack pointer after sequence |
| pc_out | output | 16 | PC after sequence |

## Verification
Completion of one sequence and acceptance of the next can fall in the same cycle, because the block is idle during its `done` pulse and takes a new start there. The bench raises a new start in the `done` cycle of a one-byte push. It then checks that the first sequence's pointer is intact in that cycle and that the following pull returns the pushed byte with the right pointer. A second overlap is a start strobe raised while busy. The bench judges it by the unchanged access count, pointer and memory contents of the running push.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int BW = 8,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pull,
  input  logic          use_u,
  input  logic [7:0]    mask,
  input  logic [BW-1:0] cc_in,
  input  logic [BW-1:0] a_in,
  input  logic [BW-1:0] b_in,
  input  logic [BW-1:0] dp_in,
  input  logic [2*BW-1:0] x_in,
  input  logic [2*BW-1:0] y_in,
  input  logic [2*BW-1:0] s_in,
  input  logic [2*BW-1:0] u_in,
  input  logic [2*BW-1:0] pc_in,
  output logic [2*BW-1:0] mem_addr,
  output logic          mem_wr,
  output logic          mem_rd,
  output logic [BW-1:0] mem_wdata,
  input  logic [BW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [2*BW-1:0] sp_out,
  output logic [CW-1:0] cyc_out,
  output logic [BW-1:0] cc_out,
  output logic [BW-1:0] a_out,
  output logic [BW-1:0] b_out,
  output logic [BW-1:0] dp_out,
  output logic [2*BW-1:0] x_out,
  output logic [2*BW-1:0] y_out,
  output logic [2*BW-1:0] osp_out,
  output logic [2*BW-1:0] pc_out
);
  localparam int WW = 2 * BW;
  localparam int NR = 8;
  localparam int FIRST_WORD = 4;

  logic [WW-1:0] rf [NR];
  logic [NR-1:0] pend, pend_nx;
  logic [2:0]    cur;
  logic          dir, ph, word, last_byte;
  logic [WW-1:0] ptr, ptr_nx;
  logic [CW-1:0] cyc;

  // push takes the highest pending bit, pull the lowest
  always_comb begin
    cur = '0;
    if (dir) begin
      for (int i = NR - 1; i >= 0; i--)
        if (pend[i]) cur = 3'(i);
    end else begin
      for (int i = 0; i < NR; i++)
        if (pend[i]) cur = 3'(i);
    end
  end

  assign word      = (int'(cur) >= FIRST_WORD);
  assign last_byte = !word || ph;
  assign pend_nx   = last_byte ? (pend & ~(NR'(1) << cur)) : pend;
  assign ptr_nx    = dir ? ptr + 1'b1 : ptr - 1'b1;

  assign mem_addr  = dir ? ptr : ptr - 1'b1;
  assign mem_wr    = busy && !dir;
  assign mem_rd    = busy && dir;
  assign mem_wdata = (word && ph) ? rf[cur][WW-1:BW] : rf[cur][BW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) rf[i] <= '0;
      pend    <= '0;
      dir     <= 1'b0;
      ph      <= 1'b0;
      ptr     <= '0;
      cyc     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      sp_out  <= '0;
      cyc_out <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        dir   <= pull;
        pend  <= mask;
        ptr   <= use_u ? u_in : s_in;
        cyc   <= '0;
        ph    <= 1'b0;
        rf[0] <= WW'(cc_in);
        rf[1] <= WW'(a_in);
        rf[2] <= WW'(b_in);
        rf[3] <= WW'(dp_in);
        rf[4] <= x_in;
        rf[5] <= y_in;
        rf[6] <= use_u ? s_in : u_in;
        rf[7] <= pc_in;
        if (mask == '0) begin
          done    <= 1'b1;
          sp_out  <= use_u ? u_in : s_in;
          cyc_out <= '0;
        end else begin
          busy <= 1'b1;
        end
      end else if (busy) begin
        ptr  <= ptr_nx;
        cyc  <= cyc + 1'b1;
        ph   <= word && !ph;
        pend <= pend_nx;
        if (dir) begin
          if (word && !ph) rf[cur][WW-1:BW] <= mem_rdata;
          else             rf[cur][BW-1:0]  <= mem_rdata;
        end
        if (pend_nx == '0) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          sp_out  <= ptr_nx;
          cyc_out <= cyc + 1'b1;
        end
      end
    end
  end

  assign cc_out  = rf[0][BW-1:0];
  assign a_out   = rf[1][BW-1:0];
  assign b_out   = rf[2][BW-1:0];
  assign dp_out  = rf[3][BW-1:0];
  assign x_out   = rf[4];
  assign y_out   = rf[5];
  assign osp_out = rf[6];
  assign pc_out  = rf[7];
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int BW = 8,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [7:0]    mask,
  input logic          busy,
  input logic          done,
  input logic          mem_wr,
  input logic          mem_rd,
  input logic [2*BW-1:0] mem_addr,
  input logic [CW-1:0] cyc_out
);
  a_r11_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr, mem_rd}));

  a_r9_access_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || mem_rd) |-> busy);

  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_wr && !mem_rd);

  a_r2_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_wr)) |-> mem_addr == $past(mem_addr) - 1'b1);

  a_r3_pull_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> mem_addr == $past(mem_addr) + 1'b1);

  a_r7_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mask == 8'h00) |=> done && !mem_wr && !mem_rd);

  a_r5_cycle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cyc_out <= CW'(12));
endmodule

bind stack_seq stack_seq_chk #(.BW(BW), .CW(CW)) u_chk (.*);

// File: tb/stack_seq_bench.sv
module stack_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, start = 0, pull = 0, use_u = 0;
  logic [7:0] mask = 0, cc_in = 0, a_in = 0, b_in = 0, dp_in = 0;
  logic [15:0] x_in = 0, y_in = 0, s_in = 0, u_in = 0, pc_in = 0;
  logic [15:0] mem_addr, sp_out, x_out, y_out, osp_out, pc_out;
  logic mem_wr, mem_rd, busy, done;
  logic [7:0] mem_wdata, mem_rdata, cc_out, a_out, b_out, dp_out;
  logic [4:0] cyc_out;
  logic [7:0] mem [256];
  int errors = 0, checks = 0, acc = 0;
  logic [15:0] first_a, last_a;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_seq u_stack_seq (.*);

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  always @(negedge clk) if (mem_wr || mem_rd) begin
    if (acc == 0) first_a = mem_addr;
    last_a = mem_addr;
    acc++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic go(input logic p, input logic u, input logic [7:0] m);
    pull = p; use_u = u; mask = m; acc = 0;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 60 && !done; n++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 busy", busy, 0);
    chk("R9 done", done, 0);
    chk("R9 access", mem_wr | mem_rd, 0);
  endtask

  task automatic t_push_all();
    s_in = 16'h0080; u_in = 16'h1234; x_in = 16'h5566; y_in = 16'h7788;
    pc_in = 16'h9ABC; cc_in = 8'h11; a_in = 8'h22; b_in = 8'h33; dp_in = 8'h44;
    go(0, 0, 8'hFF);
    wait_done();
    chk("R5 cycles", cyc_out, 12);
    chk("R5 accesses", acc, 12);
    chk("R6 sp", sp_out, 16'h0074);
    chk("R2 first addr", first_a, 16'h007F);
    chk("R2 last addr", last_a, 16'h0074);
    chk("R2 pc", {mem[8'h7E], mem[8'h7F]}, 16'h9ABC);
    chk("R4 u stacked", {mem[8'h7C], mem[8'h7D]}, 16'h1234);
    chk("R1 y", {mem[8'h7A], mem[8'h7B]}, 16'h7788);
    chk("R1 x", {mem[8'h78], mem[8'h79]}, 16'h5566);
    chk("R1 bytes", {mem[8'h77], mem[8'h76], mem[8'h75], mem[8'h74]}, 32'h44332211);
  endtask

  task automatic t_pull_all();
    s_in = 16'hAAAA; u_in = 16'h0074; x_in = 0; y_in = 0; pc_in = 0;
    cc_in = 0; a_in = 0; b_in = 0; dp_in = 0;
    go(1, 1, 8'hFF);
    wait_done();
    chk("R3 first addr", first_a, 16'h0074);
    chk("R3 last addr", last_a, 16'h007F);
    chk("R6 sp", sp_out, 16'h0080);
    chk("R10 bytes", {dp_out, b_out, a_out, cc_out}, 32'h44332211);
    chk("R10 x", x_out, 16'h5566);
    chk("R10 y", y_out, 16'h7788);
    chk("R4 s pulled", osp_out, 16'h1234);
    chk("R10 pc", pc_out, 16'h9ABC);
  endtask

  task automatic t_other_sp();
    u_in = 16'h0060; s_in = 16'hBEEF;
    go(0, 1, 8'h40);
    wait_done();
    chk("R4 s on u", {mem[8'h5E], mem[8'h5F]}, 16'hBEEF);
    chk("R6 sp", sp_out, 16'h005E);
    chk("R5 cycles", cyc_out, 2);
    s_in = 16'h0050; u_in = 16'hCAFE;
    go(0, 0, 8'h40);
    wait_done();
    chk("R4 u on s", {mem[8'h4E], mem[8'h4F]}, 16'hCAFE);
  endtask

  task automatic t_partial_pull();
    s_in = 16'h0074; b_in = 8'h5A; y_in = 16'hD00D; a_in = 0; x_in = 0;
    go(1, 0, 8'h12);
    wait_done();
    chk("R3 a first", a_out, 8'h11);
    chk("R3 x next", x_out, 16'h2233);
    chk("R10 b kept", b_out, 8'h5A);
    chk("R10 y kept", y_out, 16'hD00D);
    chk("R6 sp", sp_out, 16'h0077);
    chk("R5 cycles", cyc_out, 3);
  endtask

  task automatic t_zero();
    s_in = 16'h4321;
    go(0, 0, 8'h00);
    chk("R7 done next cycle", done, 1);
    chk("R7 sp", sp_out, 16'h4321);
    chk("R7 cycles", cyc_out, 0);
    chk("R7 no access", acc, 0);
    @(negedge clk);
    chk("R11 done pulse", done, 0);
  endtask

  task automatic t_busy_ignore();
    s_in = 16'h0040; pc_in = 16'h1357;
    go(0, 0, 8'h80);
    mask = 8'hFF; pull = 1; start = 1;
    @(negedge clk);
    start = 0;
    wait_done();
    chk("R8 accesses", acc, 2);
    chk("R8 sp", sp_out, 16'h003E);
    chk("R8 data", {mem[8'h3E], mem[8'h3F]}, 16'h1357);
  endtask

  task automatic t_back_to_back();
    s_in = 16'h0030; cc_in = 8'h99;
    go(0, 0, 8'h01);
    wait_done();
    chk("R11 done", done, 1);
    chk("R6 first sp", sp_out, 16'h002F);
    s_in = 16'h002F; cc_in = 8'h00;
    go(1, 0, 8'h01);
    wait_done();
    chk("R3 cc back", cc_out, 8'h99);
    chk("R6 second sp", sp_out, 16'h0030);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_push_all();
    t_pull_all();
    t_other_sp();
    t_partial_pull();
    t_zero();
    t_busy_ignore();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule